// File: doc/BRIEF.md
# FIFO Partial-Flag Threshold Loader

This block stores the two thresholds that a FIFO's partial flags compare against: an almost-empty offset and an almost-full offset. Each is as wide as the FIFO address. After a master reset both hold parameterised defaults, so the flags are usable before software programs anything. The loading method is chosen by an input sampled while master reset is high. In serial mode, bits arrive one per write-clock edge on a single-bit input. In parallel mode, whole words come from the data bus, and a write pointer alternates between the two registers.

Every sequence can be paused and then resumed from the same point. The serial bit position, the parallel write pointer and the readback pointer all keep their place while the load strobe or the relevant enable is deasserted. During a pause, ordinary FIFO traffic uses the bus. Readback runs on the read clock with its own pointer and drives the selected threshold onto the output bus. The block also gives a "programmed" indication for each register, and a combinational usage-error flag that rises when a write and a readback target the same register in the same cycle.

Top module: `fifo_ofs_loader`

## Requirements
- R1: While `mrst` is high on a clock edge, the thresholds return to `AE_DEF`/`AF_DEF` and both programmed indications clear. After that edge `rd_data` is zero, and both the write pointer and the readback pointer select the almost-empty register.
- R2: The load mode is taken from `mode_ser` on each edge where `mrst` is high: 1 selects serial loading and 0 selects parallel loading. The mode then holds until the next master reset.
- R3: In parallel mode, a write-clock edge with `load_n`=0 and `wr_en_n`=0 stores the low `OFS_W` bits of `wr_data` into the register the write pointer selects. It also sets that register's programmed indication. The pointer then alternates: almost-empty, almost-full, almost-empty.
- R4: In parallel mode, an edge with `load_n`=1 or `wr_en_n`=1 changes no threshold and does not move the write pointer. The next enabled write therefore goes to the next register in the sequence.
- R5: In serial mode, the k-th accepted bit (k counted from 0, with `ser_in` on an edge with `load_n`=0 and `ser_en_n`=0) is written to bit k of the almost-empty offset for k < `OFS_W`. Otherwise it goes to bit k-`OFS_W` of the almost-full offset. After 2*`OFS_W` bits the position wraps to 0.
- R6: In serial mode, the first bit of a sequence clears both programmed indications, and the last bit sets both. Parallel write strobes are ignored in serial mode, and serial strobes are ignored in parallel mode.
- R7: In serial mode, an edge with `load_n`=1 or `ser_en_n`=1 takes no bit and keeps the bit position.
- R8: A read-clock edge with `load_n`=0 and `rd_en_n`=0 loads `rd_data` with the zero-extended register that the readback pointer selects, and then advances the pointer in the order almost-empty, almost-full, almost-empty. Any other edge holds both `rd_data` and the pointer.
- R9: While `prst` is high (and `mrst` is low), no write or readback takes place. Thresholds, indications, pointers, bit position, mode and `rd_data` keep their values.
- R10: `usage_err` is high whenever a write that would be accepted and a readback that would be accepted select the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| mode_ser | input | 1 | Load mode, sampled during master reset (1 = serial) |
| load_n | input | 1 | Threshold access strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| ser_en_n | input | 1 | Serial enable, active low |
| ser_in | input | 1 | Serial threshold bit |
| wr_data | input | DATA_W | Write data bus |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | DATA_W | Readback bus |
| ae_ofs | output | OFS_W | Almost-empty threshold |
| af_ofs | output | OFS_W | Almost-full threshold |
| ae_prog | output | 1 | Almost-empty threshold programmed |
| af_prog | output | 1 | Almost-full threshold programmed |
| usage_err | output | 1 | Same register written and read in one cycle |

## Verification
The bench builds the block with `OFS_W`=5, `DATA_W`=8, `AE_DEF`=3 and `AF_DEF`=7. With these values a complete serial sequence takes only ten bits, so mid-sequence pauses and the wrap into a fresh sequence fit in a short run. The bus is wider than the offset, which puts the truncation of wide parallel words and the zero-extension of readback values within reach.

// File: rtl/fifo_ofs_pkg.sv
`timescale 1ns/1ps
package fifo_ofs_pkg;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;

    typedef enum logic {
        MODE_PAR = 1'b0,
        MODE_SER = 1'b1
    } load_mode_e;

    typedef struct packed {
        logic     word_we;
        ofs_sel_e word_sel;
        logic     bit_we;
        ofs_sel_e bit_sel;
        logic     seq_first;
        logic     seq_last;
    } wr_req_t;

    function automatic ofs_sel_e sel_next(input ofs_sel_e s);
        return (s == SEL_AE) ? SEL_AF : SEL_AE;
    endfunction

    function automatic load_mode_e mode_decode(input logic ser);
        return ser ? MODE_SER : MODE_PAR;
    endfunction

endpackage

// File: rtl/fifo_ofs_wr_ctrl.sv
`timescale 1ns/1ps
module fifo_ofs_wr_ctrl
    import fifo_ofs_pkg::*;
#(
    parameter int OFS_W = 13
) (
    input  logic                              clk,
    input  logic                              mrst,
    input  logic                              prst,
    input  logic                              mode_ser,
    input  logic                              load_n,
    input  logic                              wr_en_n,
    input  logic                              ser_en_n,
    output load_mode_e                        mode,
    output wr_req_t                           req,
    output logic [$clog2(OFS_W)-1:0]          bit_idx
);
    localparam int SEQ_LEN = 2 * OFS_W;
    localparam int POS_W   = $clog2(SEQ_LEN);
    localparam int IDX_W   = $clog2(OFS_W);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(SEQ_LEN - 1);
    localparam logic [POS_W-1:0] POS_HALF = POS_W'(OFS_W);

    load_mode_e       mode_q;
    ofs_sel_e         wsel_q;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] rel_pos;
    logic             active;
    logic             par_take;
    logic             ser_take;
    logic             pos_hi;

    assign active   = !mrst && !prst && !load_n;
    assign par_take = active && (mode_q == MODE_PAR) && !wr_en_n;
    assign ser_take = active && (mode_q == MODE_SER) && !ser_en_n;
    assign pos_hi   = (pos_q >= POS_HALF);
    assign rel_pos  = pos_hi ? (pos_q - POS_HALF) : pos_q;

    always_ff @(posedge clk) begin
        if (mrst) begin
            mode_q <= mode_decode(mode_ser);
            wsel_q <= SEL_AE;
            pos_q  <= '0;
        end else begin
            if (par_take)
                wsel_q <= sel_next(wsel_q);
            if (ser_take)
                pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
        end
    end

    always_comb begin
        req.word_we   = par_take;
        req.word_sel  = wsel_q;
        req.bit_we    = ser_take;
        req.bit_sel   = pos_hi ? SEL_AF : SEL_AE;
        req.seq_first = (pos_q == '0);
        req.seq_last  = (pos_q == POS_LAST);
    end

    assign bit_idx = rel_pos[IDX_W-1:0];
    assign mode    = mode_q;

endmodule

// File: rtl/fifo_ofs_regs.sv
`timescale 1ns/1ps
module fifo_ofs_regs
    import fifo_ofs_pkg::*;
#(
    parameter int              OFS_W  = 13,
    parameter logic [OFS_W-1:0] AE_DEF = OFS_W'(127),
    parameter logic [OFS_W-1:0] AF_DEF = OFS_W'(127)
) (
    input  logic                     clk,
    input  logic                     mrst,
    input  wr_req_t                  req,
    input  logic [$clog2(OFS_W)-1:0] bit_idx,
    input  logic                     bit_val,
    input  logic [OFS_W-1:0]         word,
    output logic [2*OFS_W-1:0]       ofs_flat,
    output logic [1:0]               prog
);
    for (genvar i = 0; i < 2; i++) begin : g_ofs
        localparam ofs_sel_e         ME  = (i == 0) ? SEL_AE : SEL_AF;
        localparam logic [OFS_W-1:0] DEF = (i == 0) ? AE_DEF : AF_DEF;

        logic [OFS_W-1:0] val_q;
        logic             prog_q;

        always_ff @(posedge clk) begin
            if (mrst) begin
                val_q  <= DEF;
                prog_q <= 1'b0;
            end else begin
                if (req.word_we && req.word_sel == ME) begin
                    val_q  <= word;
                    prog_q <= 1'b1;
                end
                if (req.bit_we) begin
                    if (req.bit_sel == ME)
                        val_q[bit_idx] <= bit_val;
                    if (req.seq_last)
                        prog_q <= 1'b1;
                    else if (req.seq_first)
                        prog_q <= 1'b0;
                end
            end
        end

        assign ofs_flat[i*OFS_W +: OFS_W] = val_q;
        assign prog[i]                    = prog_q;
    end

endmodule

// File: rtl/fifo_ofs_rdback.sv
`timescale 1ns/1ps
module fifo_ofs_rdback
    import fifo_ofs_pkg::*;
#(
    parameter int OFS_W  = 13,
    parameter int DATA_W = 18
) (
    input  logic                 clk,
    input  logic                 mrst,
    input  logic                 prst,
    input  logic                 load_n,
    input  logic                 rd_en_n,
    input  logic [2*OFS_W-1:0]   ofs_flat,
    output logic [DATA_W-1:0]    rd_data,
    output ofs_sel_e             rd_sel,
    output logic                 rd_take
);
    ofs_sel_e          rsel_q;
    logic [DATA_W-1:0] data_q;
    logic [OFS_W-1:0]  picked;

    assign rd_take = !mrst && !prst && !load_n && !rd_en_n;
    assign picked  = (rsel_q == SEL_AF) ? ofs_flat[OFS_W +: OFS_W]
                                        : ofs_flat[0 +: OFS_W];

    always_ff @(posedge clk) begin
        if (mrst) begin
            rsel_q <= SEL_AE;
            data_q <= '0;
        end else if (rd_take) begin
            rsel_q <= sel_next(rsel_q);
            data_q <= DATA_W'(picked);
        end
    end

    assign rd_data = data_q;
    assign rd_sel  = rsel_q;

endmodule

// File: rtl/fifo_ofs_loader.sv
`timescale 1ns/1ps
module fifo_ofs_loader
    import fifo_ofs_pkg::*;
#(
    parameter int               OFS_W  = 13,
    parameter int               DATA_W = 18,
    parameter logic [OFS_W-1:0] AE_DEF = OFS_W'(127),
    parameter logic [OFS_W-1:0] AF_DEF = OFS_W'(127)
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              mode_ser,
    input  logic              load_n,
    input  logic              wr_en_n,
    input  logic              ser_en_n,
    input  logic              ser_in,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic [OFS_W-1:0]  ae_ofs,
    output logic [OFS_W-1:0]  af_ofs,
    output logic              ae_prog,
    output logic              af_prog,
    output logic              usage_err
);
    localparam int IDX_W = $clog2(OFS_W);

    load_mode_e           mode_q;
    wr_req_t              req;
    logic [IDX_W-1:0]     bit_idx;
    logic [2*OFS_W-1:0]   ofs_flat;
    logic [1:0]           prog;
    ofs_sel_e             rd_sel;
    logic                 rd_take;

    fifo_ofs_wr_ctrl #(.OFS_W(OFS_W)) u_wr (
        .clk      (wr_clk),
        .mrst     (mrst),
        .prst     (prst),
        .mode_ser (mode_ser),
        .load_n   (load_n),
        .wr_en_n  (wr_en_n),
        .ser_en_n (ser_en_n),
        .mode     (mode_q),
        .req      (req),
        .bit_idx  (bit_idx)
    );

    fifo_ofs_regs #(.OFS_W(OFS_W), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_regs (
        .clk      (wr_clk),
        .mrst     (mrst),
        .req      (req),
        .bit_idx  (bit_idx),
        .bit_val  (ser_in),
        .word     (wr_data[OFS_W-1:0]),
        .ofs_flat (ofs_flat),
        .prog     (prog)
    );

    fifo_ofs_rdback #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rd (
        .clk      (rd_clk),
        .mrst     (mrst),
        .prst     (prst),
        .load_n   (load_n),
        .rd_en_n  (rd_en_n),
        .ofs_flat (ofs_flat),
        .rd_data  (rd_data),
        .rd_sel   (rd_sel),
        .rd_take  (rd_take)
    );

    assign ae_ofs  = ofs_flat[0 +: OFS_W];
    assign af_ofs  = ofs_flat[OFS_W +: OFS_W];
    assign ae_prog = prog[0];
    assign af_prog = prog[1];

    assign usage_err = rd_take &&
                       ((req.word_we && req.word_sel == rd_sel) ||
                        (req.bit_we  && req.bit_sel  == rd_sel));

endmodule

// File: rtl/fifo_ofs_loader_chk.sv
`timescale 1ns/1ps
module fifo_ofs_loader_chk
    import fifo_ofs_pkg::*;
#(
    parameter int               OFS_W  = 13,
    parameter int               DATA_W = 18,
    parameter logic [OFS_W-1:0] AE_DEF = OFS_W'(127),
    parameter logic [OFS_W-1:0] AF_DEF = OFS_W'(127)
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              mrst,
    input logic              prst,
    input logic              load_n,
    input logic              wr_en_n,
    input logic              ser_en_n,
    input logic              rd_en_n,
    input load_mode_e        mode_q,
    input logic [OFS_W-1:0]  ae_ofs,
    input logic [OFS_W-1:0]  af_ofs,
    input logic              ae_prog,
    input logic              af_prog,
    input logic [DATA_W-1:0] rd_data
);
    // R1: master reset restores defaults and clears indications
    assert_reset_defaults_R1: assert property (@(posedge wr_clk) disable iff (prst)
        mrst |=> (ae_ofs == AE_DEF && af_ofs == AF_DEF && !ae_prog && !af_prog));

    // R3: an accepted parallel write marks a register as programmed
    assert_par_write_marks_R3: assert property (@(posedge wr_clk) disable iff (mrst)
        (mode_q == MODE_PAR && !prst && !load_n && !wr_en_n) |=> (ae_prog || af_prog));

    // R6: in serial mode both indications move together
    assert_serial_prog_pair_R6: assert property (@(posedge wr_clk) disable iff (mrst)
        (mode_q == MODE_SER) |-> (ae_prog == af_prog));

    // R7: paused serial loading leaves thresholds untouched
    assert_serial_pause_R7: assert property (@(posedge wr_clk) disable iff (mrst)
        (mode_q == MODE_SER && (load_n || ser_en_n)) |=>
            ($stable(ae_ofs) && $stable(af_ofs)));

    // R8: readback bus holds when not strobed
    assert_rdback_hold_R8: assert property (@(posedge rd_clk) disable iff (mrst)
        (load_n || rd_en_n) |=> $stable(rd_data));

    // R9: partial reset freezes threshold state
    assert_partial_freeze_R9: assert property (@(posedge wr_clk) disable iff (mrst)
        prst |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(ae_prog) && $stable(af_prog)));

endmodule

bind fifo_ofs_loader fifo_ofs_loader_chk #(
    .OFS_W(OFS_W), .DATA_W(DATA_W), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)
) u_chk (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .mrst     (mrst),
    .prst     (prst),
    .load_n   (load_n),
    .wr_en_n  (wr_en_n),
    .ser_en_n (ser_en_n),
    .rd_en_n  (rd_en_n),
    .mode_q   (mode_q),
    .ae_ofs   (ae_ofs),
    .af_ofs   (af_ofs),
    .ae_prog  (ae_prog),
    .af_prog  (af_prog),
    .rd_data  (rd_data)
);

// File: tb/sim_fifo_ofs_loader.sv
`timescale 1ns/1ps
module sim_fifo_ofs_loader;
    localparam int OFS_W  = 5;
    localparam int DATA_W = 8;
    localparam logic [OFS_W-1:0] AE_DEF = 5'd3;
    localparam logic [OFS_W-1:0] AF_DEF = 5'd7;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              mrst = 1'b1, prst = 1'b0, mode_ser = 1'b0;
    logic              load_n = 1'b1, wr_en_n = 1'b1, ser_en_n = 1'b1, ser_in = 1'b0;
    logic              rd_en_n = 1'b1;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [OFS_W-1:0]  ae_ofs, af_ofs;
    logic              ae_prog, af_prog, usage_err;

    fifo_ofs_loader #(.OFS_W(OFS_W), .DATA_W(DATA_W), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u0 (
        .wr_clk(clk), .rd_clk(clk), .mrst(mrst), .prst(prst), .mode_ser(mode_ser),
        .load_n(load_n), .wr_en_n(wr_en_n), .ser_en_n(ser_en_n), .ser_in(ser_in),
        .wr_data(wr_data), .rd_en_n(rd_en_n), .rd_data(rd_data),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ae_prog(ae_prog), .af_prog(af_prog),
        .usage_err(usage_err)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req, input int ae, input int af,
                               input int pr, input int dq);
        check(req, "ae_ofs",  int'(ae_ofs), ae);
        check(req, "af_ofs",  int'(af_ofs), af);
        check(req, "prog",    int'({af_prog, ae_prog}), pr);
        check(req, "rd_data", int'(rd_data), dq);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        load_n = 1'b1; wr_en_n = 1'b1; ser_en_n = 1'b1; rd_en_n = 1'b1; ser_in = 1'b0;
    endtask

    task automatic sbit(input logic b);
        load_n = 1'b0; ser_en_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; ser_in = b;
        tick();
    endtask

    // ld, wen, ren, din, ae, af, prog{af,ae}, dout, req number
    typedef struct packed {
        logic        ld;
        logic        wen;
        logic        ren;
        logic [7:0]  din;
        logic [4:0]  ae;
        logic [4:0]  af;
        logic [1:0]  pr;
        logic [7:0]  dq;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b1, 8'h15, 5'd21, 5'd7,  2'b01, 8'd0,  4'd3},
        '{1'b1, 1'b0, 1'b1, 8'h0A, 5'd21, 5'd7,  2'b01, 8'd0,  4'd4},
        '{1'b0, 1'b1, 1'b1, 8'h0B, 5'd21, 5'd7,  2'b01, 8'd0,  4'd4},
        '{1'b0, 1'b0, 1'b1, 8'h2C, 5'd21, 5'd12, 2'b11, 8'd0,  4'd3},
        '{1'b0, 1'b0, 1'b1, 8'h09, 5'd9,  5'd12, 2'b11, 8'd0,  4'd3},
        '{1'b0, 1'b1, 1'b0, 8'h00, 5'd9,  5'd12, 2'b11, 8'd9,  4'd8},
        '{1'b1, 1'b1, 1'b0, 8'h00, 5'd9,  5'd12, 2'b11, 8'd9,  4'd8},
        '{1'b0, 1'b1, 1'b0, 8'h00, 5'd9,  5'd12, 2'b11, 8'd12, 4'd8},
        '{1'b0, 1'b1, 1'b0, 8'h00, 5'd9,  5'd12, 2'b11, 8'd9,  4'd8},
        '{1'b0, 1'b0, 1'b1, 8'h1F, 5'd9,  5'd31, 2'b11, 8'd9,  4'd3},
        '{1'b0, 1'b1, 1'b0, 8'h00, 5'd9,  5'd31, 2'b11, 8'd31, 4'd8}
    };

    function automatic string req_name(input logic [3:0] n);
        case (n)
            4'd3:    return "R3";
            4'd4:    return "R4";
            default: return "R8";
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 / R2: master reset in parallel mode
        mrst = 1'b1; mode_ser = 1'b0; idle();
        tick(); tick();
        mrst = 1'b0;
        check_state("R1", 3, 7, 0, 0);
        check("R1", "usage_err", int'(usage_err), 0);

        // R3 R4 R8: table walk in parallel mode
        foreach (VEC[i]) begin
            load_n = VEC[i].ld; wr_en_n = VEC[i].wen; rd_en_n = VEC[i].ren;
            wr_data = VEC[i].din; ser_en_n = 1'b1;
            tick();
            check_state(req_name(VEC[i].rq), int'(VEC[i].ae), int'(VEC[i].af),
                        int'(VEC[i].pr), int'(VEC[i].dq));
        end
        idle();

        // R6: serial strobes ignored in parallel mode
        load_n = 1'b0; ser_en_n = 1'b0; ser_in = 1'b1;
        tick(); tick();
        idle();
        check_state("R6", 9, 31, 3, 31);

        // R9: partial reset blocks writes and readback
        prst = 1'b1; load_n = 1'b0; wr_en_n = 1'b0; rd_en_n = 1'b0; wr_data = 8'h04;
        tick(); tick();
        check_state("R9", 9, 31, 3, 31);
        prst = 1'b0; rd_en_n = 1'b1;
        tick();
        check_state("R9", 4, 31, 3, 31);
        wr_en_n = 1'b1; rd_en_n = 1'b0;
        tick();
        check_state("R9", 4, 31, 3, 4);
        idle();

        // R10: write pointer and read pointer both on almost-full
        load_n = 1'b0; wr_en_n = 1'b0; rd_en_n = 1'b0;
        #1;
        check("R10", "usage_err same reg", int'(usage_err), 1);
        idle();
        #1;
        check("R10", "usage_err idle", int'(usage_err), 0);

        // R1 R2: master reset into serial mode
        tick();
        mrst = 1'b1; mode_ser = 1'b1;
        tick(); tick();
        mrst = 1'b0; mode_ser = 1'b0;
        check_state("R1", 3, 7, 0, 0);
        load_n = 1'b0; rd_en_n = 1'b0;
        tick();
        check("R1", "readback pointer at almost-empty", int'(rd_data), 3);
        idle();

        // R5: first three bits, LSB first (0,1,1)
        sbit(1'b0); sbit(1'b1); sbit(1'b1);
        idle();
        check("R5", "ae after 3 bits", int'(ae_ofs), 6);
        check("R2", "serial prog still clear", int'({af_prog, ae_prog}), 0);

        // R7: pauses; R6: parallel write ignored in serial mode
        load_n = 1'b0; ser_en_n = 1'b1; ser_in = 1'b1; tick();
        load_n = 1'b1; ser_en_n = 1'b0; ser_in = 1'b1; tick();
        load_n = 1'b0; ser_en_n = 1'b1; wr_en_n = 1'b0; wr_data = 8'h1F; tick();
        idle();
        check("R7", "ae held in pause", int'(ae_ofs), 6);
        check("R6", "af not written by parallel", int'(af_ofs), 7);

        // R5: remaining bits: ae bits 3,4 = 0,1 ; af = 1,0,1,1,0
        sbit(1'b0); sbit(1'b1);
        sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b1); sbit(1'b0);
        idle();
        check("R5", "ae full", int'(ae_ofs), 22);
        check("R5", "af full", int'(af_ofs), 13);
        check("R6", "prog after last bit", int'({af_prog, ae_prog}), 3);

        // R8: readback pointer now on almost-full
        load_n = 1'b0; rd_en_n = 1'b0;
        tick();
        idle();
        check("R8", "serial readback af", int'(rd_data), 13);

        // R6: wrap, first bit of a fresh sequence clears indications
        sbit(1'b1);
        idle();
        check("R5", "wrapped bit 0", int'(ae_ofs), 23);
        check("R6", "prog cleared on restart", int'({af_prog, ae_prog}), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule